// File: doc/BRIEF.md
# Decode-Stage Branch Resolver

This block settles the direction and destination of a branch while the branch is still in the decode stage of a simple in-order pipeline. A taken branch therefore costs one fetch slot instead of two. Every cycle it reads the decoded branch kind, a signed word offset, the PC of the instruction being decoded, and the two raw register-file read values. A private adder forms a candidate target for every instruction, whether or not it is a branch. A comparator checks the two operands for equality.

The block also holds the fetch PC. The fetch PC steps forward by one instruction every cycle unless a taken branch redirects it to the computed target. A mode input selects how the single wrong-path instruction is handled:
- In flush mode, a flush pulse tells fetch to discard that instruction. The block also ignores that instruction when it reaches decode one cycle later.
- In delay-slot mode, the instruction is treated as an architectural slot that always executes, so no flush is raised. If software has nothing useful to place there, it fills the slot with a NOP.

Top module: `dec_branch_unit`

## Requirements
- R1: While reset is low at a clock edge, the fetch PC loads `RESET_PC` (default 0). Reset also clears any pending squash, so the first instruction decoded after reset resolves normally.
- R2: `tgt_addr` always equals `dec_pc` plus the sign-extended `dec_offset` shifted left by 2, modulo 2^PC_W. This holds for every kind and for every valid state.
- R3: In any cycle without a redirect, the fetch PC increases by 4 at the next clock edge.
- R4: Kind code 1 (jump) is always taken when it is live. A live instruction is one with `dec_valid` high that is not squashed.
- R5: Kind code 2 is taken exactly when `rf_a == rf_b`. Kind code 3 is taken exactly when the two operands differ.
- R6: Kind code 0, or `dec_valid` low, never raises `redirect` or `flush`.
- R7: A taken branch raises `redirect` in the same cycle. The fetch PC equals that cycle's `tgt_addr` after the next clock edge.
- R8: With `slot_mode` low, a taken branch raises `flush` in the same cycle. The instruction decoded in the following cycle is squashed: it raises neither `redirect` nor `flush`, so each flush lasts one cycle.
- R9: With `slot_mode` high, `flush` is never raised. A taken branch still redirects, and the instruction that follows it resolves normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dec_valid | input | 1 | The decode stage holds a real instruction |
| dec_kind | input | 2 | Branch kind: 0 none, 1 jump, 2 branch-if-equal, 3 branch-if-not-equal |
| dec_offset | input | OFF_W | Signed branch offset in instruction words |
| dec_pc | input | PC_W | PC of the instruction being decoded |
| rf_a | input | DATA_W | Register-file read port A, raw |
| rf_b | input | DATA_W | Register-file read port B, raw |
| slot_mode | input | 1 | 0: flush the wrong-path instruction; 1: execute it as a delay slot |
| redirect | output | 1 | Next-PC select: load the target into the fetch PC |
| flush | output | 1 | Discard the instruction fetched behind the branch |
| tgt_addr | output | PC_W | Candidate branch target computed in decode |
| fetch_pc | output | PC_W | Current fetch PC |

## Verification
`redirect`, `flush` and `tgt_addr` are combinational from the decode inputs and from the one-bit squash register, so their results are due in the same cycle. The bench drives inputs just after a falling edge and samples these outputs 1 ns later. `fetch_pc` changes at the next rising edge, and the bench samples it 1 ns after that edge against a model that adds either 4 or the target. A squash that follows a flush shows up one cycle later still. The bench model carries a squash flag across the edge and checks the instruction that comes next.

// File: rtl/dec_branch_pkg.sv
// Shared types for the decode-stage branch resolver.
// Assumes fixed 4-byte instructions; kind codes are visible on the ports.
package dec_branch_pkg;
    typedef enum logic [1:0] {
        BR_NONE = 2'd0,
        BR_JUMP = 2'd1,
        BR_EQ   = 2'd2,
        BR_NE   = 2'd3
    } br_kind_e;

    localparam int unsigned INSN_BYTES = 4;
    localparam int unsigned INSN_SHIFT = 2;
endpackage

// File: rtl/dec_branch_target.sv
// Target adder: PC of the decoding instruction plus the word offset scaled to bytes.
// Runs for every instruction; assumes nothing about whether it is a branch.
module dec_branch_target #(
    parameter int unsigned PC_W  = 32,
    parameter int unsigned OFF_W = 16
) (
    input  logic [PC_W-1:0]  pc,
    input  logic [OFF_W-1:0] offset,
    output logic [PC_W-1:0]  target
);
    import dec_branch_pkg::*;

    logic [PC_W-1:0] off_ext;

    generate
        if (PC_W > OFF_W) begin : g_extend
            // Sign-extend a narrow offset up to PC width.
            assign off_ext = {{(PC_W-OFF_W){offset[OFF_W-1]}}, offset};
        end else begin : g_trunc
            // Offset at least as wide as the PC: keep the low bits.
            assign off_ext = offset[PC_W-1:0];
        end
    endgenerate

    // Byte-scaled sum.
    always_comb begin
        target = pc + (off_ext << INSN_SHIFT);
    end
endmodule

// File: rtl/dec_branch_cond.sv
// Condition unit: decides taken/not-taken from the kind and the raw operands.
// Assumes the operands come straight from the register file (no forwarding).
module dec_branch_cond #(
    parameter int unsigned DATA_W = 32
) (
    input  dec_branch_pkg::br_kind_e kind,
    input  logic [DATA_W-1:0]        op_a,
    input  logic [DATA_W-1:0]        op_b,
    output logic                     taken
);
    import dec_branch_pkg::*;

    logic same;

    // Operand equality.
    always_comb begin
        same = (op_a == op_b);
    end

    // Direction per kind.
    always_comb begin
        unique case (kind)
            BR_JUMP: taken = 1'b1;
            BR_EQ:   taken = same;
            BR_NE:   taken = !same;
            default: taken = 1'b0;
        endcase
    end
endmodule

// File: rtl/dec_branch_fetchpc.sv
// Fetch PC register: steps by one instruction each cycle or loads a redirect target.
// Assumes the redirect and target are settled before the clock edge.
module dec_branch_fetchpc #(
    parameter int unsigned     PC_W     = 32,
    parameter logic [PC_W-1:0] RESET_PC = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [PC_W-1:0] load_val,
    output logic [PC_W-1:0] pc_q
);
    import dec_branch_pkg::*;

    localparam logic [PC_W-1:0] STEP = PC_W'(INSN_BYTES);

    // PC update: reset, redirect, or sequential step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= RESET_PC;
        end else if (load) begin
            pc_q <= load_val;
        end else begin
            pc_q <= pc_q + STEP;
        end
    end
endmodule

// File: rtl/dec_branch_unit.sv
// Decode-stage branch resolver: resolves branches one stage early, steers the fetch PC,
// and either flushes the wrong-path instruction or keeps it as a delay slot.
// Assumes at most one instruction per cycle in decode and no stalls.
module dec_branch_unit #(
    parameter int unsigned     PC_W     = 32,
    parameter int unsigned     OFF_W    = 16,
    parameter int unsigned     DATA_W   = 32,
    parameter logic [PC_W-1:0] RESET_PC = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dec_valid,
    input  logic [1:0]        dec_kind,
    input  logic [OFF_W-1:0]  dec_offset,
    input  logic [PC_W-1:0]   dec_pc,
    input  logic [DATA_W-1:0] rf_a,
    input  logic [DATA_W-1:0] rf_b,
    input  logic              slot_mode,
    output logic              redirect,
    output logic              flush,
    output logic [PC_W-1:0]   tgt_addr,
    output logic [PC_W-1:0]   fetch_pc
);
    import dec_branch_pkg::*;

    br_kind_e kind;
    logic     cond_taken;
    logic     squash_q;
    logic     live;

    // Present the kind code as the shared enum.
    always_comb begin
        kind = br_kind_e'(dec_kind);
    end

    dec_branch_target #(
        .PC_W  (PC_W),
        .OFF_W (OFF_W)
    ) u_target (
        .pc     (dec_pc),
        .offset (dec_offset),
        .target (tgt_addr)
    );

    dec_branch_cond #(
        .DATA_W (DATA_W)
    ) u_cond (
        .kind  (kind),
        .op_a  (rf_a),
        .op_b  (rf_b),
        .taken (cond_taken)
    );

    // Resolution: a live instruction that is taken redirects; flush only in flush mode.
    always_comb begin
        live     = dec_valid && !squash_q;
        redirect = live && cond_taken;
        flush    = redirect && !slot_mode;
    end

    // Remember a flush so the flushed instruction is ignored when it reaches decode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            squash_q <= 1'b0;
        end else begin
            squash_q <= flush;
        end
    end

    dec_branch_fetchpc #(
        .PC_W     (PC_W),
        .RESET_PC (RESET_PC)
    ) u_fetchpc (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (redirect),
        .load_val (tgt_addr),
        .pc_q     (fetch_pc)
    );
endmodule

// File: rtl/dec_branch_unit_chk.sv
// Property checker for the decode-stage branch resolver, bound to the top module.
module dec_branch_unit_chk #(
    parameter int unsigned PC_W   = 32,
    parameter int unsigned OFF_W  = 16,
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              dec_valid,
    input logic [1:0]        dec_kind,
    input logic [OFF_W-1:0]  dec_offset,
    input logic [PC_W-1:0]   dec_pc,
    input logic [DATA_W-1:0] rf_a,
    input logic [DATA_W-1:0] rf_b,
    input logic              slot_mode,
    input logic              redirect,
    input logic              flush,
    input logic [PC_W-1:0]   tgt_addr,
    input logic [PC_W-1:0]   fetch_pc
);
    p_seq_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !redirect |=> fetch_pc == $past(fetch_pc) + PC_W'(4));

    p_redirect_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |=> fetch_pc == $past(tgt_addr));

    p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!dec_valid || dec_kind == 2'd0) |-> (!redirect && !flush));

    p_eq_ne_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect && dec_kind == 2'd2) |-> rf_a == rf_b);

    p_flush_one_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!redirect && !flush));

    p_slot_no_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
        slot_mode |-> !flush);
endmodule

bind dec_branch_unit dec_branch_unit_chk #(
    .PC_W   (PC_W),
    .OFF_W  (OFF_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .dec_valid  (dec_valid),
    .dec_kind   (dec_kind),
    .dec_offset (dec_offset),
    .dec_pc     (dec_pc),
    .rf_a       (rf_a),
    .rf_b       (rf_b),
    .slot_mode  (slot_mode),
    .redirect   (redirect),
    .flush      (flush),
    .tgt_addr   (tgt_addr),
    .fetch_pc   (fetch_pc)
);

// File: tb/dec_branch_unit_bench.sv
// Sweep bench for the decode-stage branch resolver with an arithmetic reference model.
module dec_branch_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        dec_valid;
    logic [1:0]  dec_kind;
    logic [15:0] dec_offset;
    logic [31:0] dec_pc;
    logic [31:0] rf_a;
    logic [31:0] rf_b;
    logic        slot_mode;
    logic        redirect;
    logic        flush;
    logic [31:0] tgt_addr;
    logic [31:0] fetch_pc;

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_pc;
    logic        exp_sq;
    logic [31:0] pcv;

    always #4 clk = ~clk;

    dec_branch_unit u_dec_branch_unit (
        .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_kind(dec_kind),
        .dec_offset(dec_offset), .dec_pc(dec_pc), .rf_a(rf_a), .rf_b(rf_b),
        .slot_mode(slot_mode), .redirect(redirect), .flush(flush),
        .tgt_addr(tgt_addr), .fetch_pc(fetch_pc)
    );

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One decode cycle: drive, check combinational results, then the PC after the edge.
    task automatic step(input logic v, input logic [1:0] k, input logic [15:0] off,
                        input logic [31:0] a, input logic [31:0] b, input logic m);
        logic [31:0] etgt;
        logic        tk;
        logic        efl;
        string       rq;
        @(negedge clk);
        dec_valid = v; dec_kind = k; dec_offset = off; dec_pc = pcv;
        rf_a = a; rf_b = b; slot_mode = m;
        pcv = pcv + 32'd4;
        #1;
        etgt = dec_pc + ({{16{off[15]}}, off} << 2);
        tk   = v && !exp_sq && (k == 2'd1 || (k == 2'd2 && a == b) || (k == 2'd3 && a != b));
        efl  = tk && !m;
        chk(tgt_addr == etgt, "R2", tgt_addr, etgt);
        if (exp_sq)                 rq = "R8";
        else if (!v || k == 2'd0)   rq = "R6";
        else if (k == 2'd1)         rq = "R4";
        else                        rq = "R5";
        chk(redirect == tk, rq, 32'(redirect), 32'(tk));
        chk(flush == efl, m ? "R9" : "R8", 32'(flush), 32'(efl));
        @(posedge clk);
        exp_pc = tk ? etgt : exp_pc + 32'd4;
        exp_sq = efl;
        #1;
        chk(fetch_pc == exp_pc, tk ? "R7" : "R3", fetch_pc, exp_pc);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] offs [5];
        offs[0] = 16'h0000; offs[1] = 16'h0001; offs[2] = 16'hFFFF;
        offs[3] = 16'h7FFF; offs[4] = 16'h8000;
        pcv = 32'h0000_1000;
        // Reset with a live jump presented: flush may pulse, squash must still clear (R1).
        rst_n = 1'b0; dec_valid = 1'b1; dec_kind = 2'd1; dec_offset = 16'h0010;
        dec_pc = 32'h0000_2000; rf_a = '0; rf_b = '0; slot_mode = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk(fetch_pc == 32'h0, "R1", fetch_pc, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(redirect == 1'b1, "R1", 32'(redirect), 32'h1);
        exp_pc = 32'h0; exp_sq = 1'b0;
        @(posedge clk);
        exp_pc = 32'h0000_2040; exp_sq = 1'b1;
        #1;
        chk(fetch_pc == exp_pc, "R7", fetch_pc, exp_pc);

        // Full sweep of mode, kind, operand relation, valid and offset corners.
        for (int m = 0; m < 2; m++)
            for (int k = 0; k < 4; k++)
                for (int e = 0; e < 2; e++)
                    for (int v = 0; v < 2; v++)
                        for (int o = 0; o < 5; o++) begin
                            logic [31:0] a;
                            a = 32'h5A00_0000 + 32'(k * 97 + o);
                            step(v[0], k[1:0], offs[o], a,
                                 e[0] ? a : a ^ (32'h1 << (o * 7)), m[0]);
                        end

        // Back-to-back taken branches in each mode (R8, R9).
        step(1'b0, 2'd0, 16'h0, 32'h0, 32'h0, 1'b0);
        step(1'b1, 2'd1, 16'h0004, 32'h0, 32'h0, 1'b0);
        step(1'b1, 2'd1, 16'h0008, 32'h0, 32'h0, 1'b0);
        step(1'b1, 2'd2, 16'hFFF0, 32'h7, 32'h7, 1'b0);
        step(1'b1, 2'd1, 16'h0004, 32'h0, 32'h0, 1'b1);
        step(1'b1, 2'd1, 16'h0008, 32'h0, 32'h0, 1'b1);
        step(1'b1, 2'd3, 16'h0003, 32'h1, 32'h2, 1'b1);
        step(1'b1, 2'd2, 16'h0003, 32'h1, 32'h2, 1'b1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule